// File: doc/BRIEF.md
# Cache Line Coherence Invariant Monitor

This block is a passive checker for one cache line address in a directory-style coherence system. Each cycle it takes in the line state and line data of every caching node, the home agent's "exclusive copy granted" flag and the memory copy of the line. It keeps its own shadow register holding the latest value written to the line. A control check enforces the single-writer / multiple-reader rule. A data check requires memory, and every node holding a valid copy, to agree with the shadow value. Each kind of violation sets a sticky error flag of its own.

The shadow register starts from the memory value present while reset is asserted. After that it follows store events: it accepts a store only when the storing node holds the line Exclusive. The monitor drives nothing back into the protocol it observes. It is intended to sit beside a protocol engine in simulation or in an emulation build.

Top module: `coh_monitor`

## Requirements
- R1: A node in Exclusive (code 2'd2) while any other node is Shared (2'd1), Exclusive or code 2'd3 sets `ctrl_err`. Two Exclusive nodes also set it.
- R2: Any mix of Shared and Invalid (2'd0) nodes with no Exclusive node leaves `ctrl_err` clear.
- R3: A node reporting the undefined state code 2'd3 sets `ctrl_err`.
- R4: With `home_excl` low, `mem_data` different from the latest value sets `data_err`. With `home_excl` high, `mem_data` is not compared.
- R5: A node whose state is not Invalid sets `data_err` when its data differs from the latest value. An Invalid node's data is never compared.
- R6: While `rst_n` is low the latest value loads `mem_data`. A store (`wr_en`) updates it to `wr_data` only when node `wr_node` is Exclusive in the same cycle, and any other store leaves it unchanged. An accepted store is already the value compared in the cycle it is presented.
- R7: A violation present at the ports at a rising edge raises its flag right after that edge. Both flags then stay high until reset, which clears them.
- R8: While `rst_n` is low, no violation sets either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the latest value from `mem_data` |
| line_state | input | 2*NODES | Per-node line state, node i at bits [2i+1:2i] |
| line_data | input | DW*NODES | Per-node line data, node i at bits [DW*i+DW-1:DW*i] |
| home_excl | input | 1 | Home has granted an exclusive copy |
| mem_data | input | DW | Memory copy of the line |
| wr_en | input | 1 | Local store event |
| wr_node | input | $clog2(NODES) | Node performing the store |
| wr_data | input | DW | Value stored |
| ctrl_err | output | 1 | Sticky control coherence violation |
| data_err | output | 1 | Sticky data coherence violation |
| latest_val | output | DW | Shadow latest written value |

## Verification
The properties assume that `wr_node` names an existing node, and that every input is stable and known at the sampling edge once reset is released. The bench meets both conditions by driving all inputs at the falling edge and using only node indices below NODES. Each table vector starts from a fresh reset with a known memory value. Because the flags are sticky, this lets one vector's expected flags be stated without regard to earlier vectors.

// File: rtl/coh_mon_pkg.sv
package coh_mon_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_BAD = 2'd3
  } line_st_e;

  // single-writer / multi-reader rule from per-state population counts
  function automatic logic ctrl_rule(input int n_exc, input int n_shr, input int n_bad);
    return (n_bad != 0) || (n_exc > 1) || ((n_exc == 1) && (n_shr != 0));
  endfunction

  // a valid copy must carry the latest value
  function automatic logic copy_stale(input logic [1:0] st, input logic mismatch);
    return (st != LS_INV) && mismatch;
  endfunction

endpackage

// File: rtl/coh_ctrl_check.sv
module coh_ctrl_check #(
  parameter int NODES = 4,
  localparam int SW = 2 * NODES
) (
  input  logic [SW-1:0]    line_state,
  output logic [NODES-1:0] exc_mask,
  output logic             ctrl_viol
);
  import coh_mon_pkg::*;

  logic [NODES-1:0] shr_mask;
  logic [NODES-1:0] bad_mask;

  for (genvar g = 0; g < NODES; g++) begin : g_node
    assign exc_mask[g] = (line_state[2*g +: 2] == LS_EXC);
    assign shr_mask[g] = (line_state[2*g +: 2] == LS_SHR);
    assign bad_mask[g] = (line_state[2*g +: 2] == LS_BAD);
  end

  always_comb begin
    int n_exc;
    int n_shr;
    int n_bad;
    n_exc = 0;
    n_shr = 0;
    n_bad = 0;
    for (int i = 0; i < NODES; i++) begin
      n_exc += int'(exc_mask[i]);
      n_shr += int'(shr_mask[i]);
      n_bad += int'(bad_mask[i]);
    end
    ctrl_viol = ctrl_rule(n_exc, n_shr, n_bad);
  end

endmodule

// File: rtl/coh_latest_track.sv
module coh_latest_track #(
  parameter int NODES = 4,
  parameter int DW    = 8,
  localparam int SW = 2 * NODES,
  localparam int IW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] line_state,
  input  logic [DW-1:0] mem_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_node,
  input  logic [DW-1:0] wr_data,
  output logic          store_ok,
  output logic [DW-1:0] latest_eff,
  output logic [DW-1:0] latest_q
);
  import coh_mon_pkg::*;

  logic node_excl;

  always_comb begin
    node_excl = 1'b0;
    for (int i = 0; i < NODES; i++)
      if (int'(wr_node) == i) node_excl = (line_state[2*i +: 2] == LS_EXC);
  end

  assign store_ok   = wr_en && node_excl;
  assign latest_eff = store_ok ? wr_data : latest_q;

  always_ff @(posedge clk) begin
    if (!rst_n) latest_q <= mem_data;
    else        latest_q <= latest_eff;
  end

endmodule

// File: rtl/coh_data_check.sv
module coh_data_check #(
  parameter int NODES = 4,
  parameter int DW    = 8,
  localparam int SW = 2 * NODES,
  localparam int BW = DW * NODES
) (
  input  logic [SW-1:0] line_state,
  input  logic [BW-1:0] line_data,
  input  logic          home_excl,
  input  logic [DW-1:0] mem_data,
  input  logic [DW-1:0] latest_eff,
  output logic          data_viol
);
  import coh_mon_pkg::*;

  logic [NODES-1:0] stale_mask;
  logic             mem_stale;

  for (genvar g = 0; g < NODES; g++) begin : g_node
    assign stale_mask[g] = copy_stale(line_state[2*g +: 2],
                                      line_data[DW*g +: DW] != latest_eff);
  end

  assign mem_stale = !home_excl && (mem_data != latest_eff);
  assign data_viol = mem_stale || (|stale_mask);

endmodule

// File: rtl/coh_monitor.sv
module coh_monitor #(
  parameter int NODES = 4,
  parameter int DW    = 8,
  localparam int SW = 2 * NODES,
  localparam int BW = DW * NODES,
  localparam int IW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] line_state,
  input  logic [BW-1:0] line_data,
  input  logic          home_excl,
  input  logic [DW-1:0] mem_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_node,
  input  logic [DW-1:0] wr_data,
  output logic          ctrl_err,
  output logic          data_err,
  output logic [DW-1:0] latest_val
);

  logic [NODES-1:0] exc_mask;
  logic             ctrl_viol;
  logic             data_viol;
  logic             store_ok;
  logic [DW-1:0]    latest_eff;

  coh_ctrl_check #(.NODES(NODES)) u_ctrl (
    .line_state (line_state),
    .exc_mask   (exc_mask),
    .ctrl_viol  (ctrl_viol)
  );

  coh_latest_track #(.NODES(NODES), .DW(DW)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_state (line_state),
    .mem_data   (mem_data),
    .wr_en      (wr_en),
    .wr_node    (wr_node),
    .wr_data    (wr_data),
    .store_ok   (store_ok),
    .latest_eff (latest_eff),
    .latest_q   (latest_val)
  );

  coh_data_check #(.NODES(NODES), .DW(DW)) u_data (
    .line_state (line_state),
    .line_data  (line_data),
    .home_excl  (home_excl),
    .mem_data   (mem_data),
    .latest_eff (latest_eff),
    .data_viol  (data_viol)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_err <= 1'b0;
      data_err <= 1'b0;
    end else begin
      ctrl_err <= ctrl_err | ctrl_viol;
      data_err <= data_err | data_viol;
    end
  end

endmodule

// File: rtl/coh_monitor_chk.sv
module coh_monitor_chk #(
  parameter int NODES = 4,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             home_excl,
  input logic [DW-1:0]    mem_data,
  input logic [DW-1:0]    wr_data,
  input logic [NODES-1:0] exc_mask,
  input logic             ctrl_viol,
  input logic             data_viol,
  input logic             store_ok,
  input logic [DW-1:0]    latest_eff,
  input logic             ctrl_err,
  input logic             data_err,
  input logic [DW-1:0]    latest_val
);

  // R1: two exclusive owners must be reported
  p_two_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(exc_mask) > 1) |=> ctrl_err);

  // R1, R3: any control violation reaches the flag one edge later
  p_ctrl_report_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_viol |=> ctrl_err);

  // R4: stale memory without an exclusive grant
  p_mem_stale_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!home_excl && (mem_data != latest_eff)) |=> data_err);

  // R5: data violations reach the flag
  p_data_report_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_viol |=> data_err);

  // R6: accepted store becomes the latest value
  p_store_upd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    store_ok |=> (latest_val == $past(wr_data)));

  // R6: no accepted store leaves the latest value alone
  p_store_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !store_ok |=> $stable(latest_val));

  // R7: flags are sticky
  p_ctrl_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_err |=> ctrl_err);
  p_data_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_err |=> data_err);

  // R8: reset clears both flags
  p_reset_clear_r8: assert property (@(posedge clk)
    !rst_n |=> (!ctrl_err && !data_err));

endmodule

bind coh_monitor coh_monitor_chk #(.NODES(NODES), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .home_excl  (home_excl),
  .mem_data   (mem_data),
  .wr_data    (wr_data),
  .exc_mask   (exc_mask),
  .ctrl_viol  (ctrl_viol),
  .data_viol  (data_viol),
  .store_ok   (store_ok),
  .latest_eff (latest_eff),
  .ctrl_err   (ctrl_err),
  .data_err   (data_err),
  .latest_val (latest_val)
);

// File: tb/coh_monitor_tb.sv
module coh_monitor_tb;

  localparam int NODES = 4;
  localparam int DW    = 8;
  localparam int NV    = 12;

  typedef struct packed {
    logic [7:0]  st;
    logic [31:0] dat;
    logic        hx;
    logic [7:0]  mem;
    logic        we;
    logic [1:0]  wn;
    logic [7:0]  wd;
    logic        ec;
    logic        ed;
    logic [7:0]  el;
    logic [3:0]  rq;
  } vec_t;

  // state codes: 0 Invalid, 1 Shared, 2 Exclusive, 3 undefined; node i at bits [2i+1:2i]
  localparam vec_t VECS [NV] = '{
    '{8'h00, 32'h5A5A5A5A, 1'b0, 8'h5A, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h5A, 4'd2}, // R2 all invalid
    '{8'h02, 32'h5A5A5A5A, 1'b1, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h5A, 4'd4}, // R4 mem not compared under grant
    '{8'h22, 32'h5A5A5A5A, 1'b1, 8'h5A, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 8'h5A, 4'd1}, // R1 two exclusive
    '{8'h48, 32'h5A5A5A5A, 1'b1, 8'h5A, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 8'h5A, 4'd1}, // R1 exclusive plus shared
    '{8'h15, 32'h5A5A5A5A, 1'b0, 8'h5A, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h5A, 4'd2}, // R2 three shared
    '{8'h0C, 32'h5A5A5A5A, 1'b0, 8'h5A, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 8'h5A, 4'd3}, // R3 undefined code
    '{8'h00, 32'h5A5A5A5A, 1'b0, 8'h33, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 8'h5A, 4'd4}, // R4 stale memory
    '{8'h10, 32'h5A775A5A, 1'b0, 8'h5A, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 8'h5A, 4'd5}, // R5 stale shared copy
    '{8'h00, 32'h5A775A5A, 1'b0, 8'h5A, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h5A, 4'd5}, // R5 invalid data ignored
    '{8'h02, 32'h5A5A5AC3, 1'b1, 8'h5A, 1'b1, 2'd0, 8'hC3, 1'b0, 1'b0, 8'hC3, 4'd6}, // R6 accepted store, forwarded
    '{8'h02, 32'h5A5A5A5A, 1'b1, 8'h5A, 1'b1, 2'd1, 8'h99, 1'b0, 1'b0, 8'h5A, 4'd6}, // R6 store by invalid node ignored
    '{8'h02, 32'h5A5A5A5A, 1'b1, 8'h5A, 1'b1, 2'd0, 8'h11, 1'b0, 1'b1, 8'h11, 4'd5}  // R5 owner data lags its store
  };

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [2*NODES-1:0]   line_state = '0;
  logic [DW*NODES-1:0]  line_data = '0;
  logic                 home_excl = 1'b0;
  logic [DW-1:0]        mem_data = '0;
  logic                 wr_en = 1'b0;
  logic [1:0]           wr_node = '0;
  logic [DW-1:0]        wr_data = '0;
  logic                 ctrl_err;
  logic                 data_err;
  logic [DW-1:0]        latest_val;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  coh_monitor #(.NODES(NODES), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_state(line_state), .line_data(line_data),
    .home_excl(home_excl), .mem_data(mem_data), .wr_en(wr_en), .wr_node(wr_node),
    .wr_data(wr_data), .ctrl_err(ctrl_err), .data_err(data_err), .latest_val(latest_val)
  );

  task automatic drive(input logic [7:0] st, input logic [31:0] dat, input logic hx,
                       input logic [7:0] mem, input logic we, input logic [1:0] wn,
                       input logic [7:0] wd);
    line_state = st; line_data = dat; home_excl = hx; mem_data = mem;
    wr_en = we; wr_node = wn; wr_data = wd;
  endtask

  task automatic idle(input logic [7:0] mem);
    drive(8'h00, 32'h5A5A5A5A, 1'b1, mem, 1'b0, 2'd0, 8'h00);
  endtask

  task automatic check(input int rq, input logic ec, input logic ed, input logic [7:0] el);
    n_chk++;
    if (ctrl_err !== ec || data_err !== ed || latest_val !== el) begin
      n_bad++;
      $display("FAIL R%0d: ctrl/data/latest = %b/%b/%h, expected %b/%b/%h",
               rq, ctrl_err, data_err, latest_val, ec, ed, el);
    end
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // table walk: fresh reset with memory 5A, one vector, then idle to show stickiness (R7)
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      rst_n = 1'b0;
      idle(8'h5A);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      drive(VECS[v].st, VECS[v].dat, VECS[v].hx, VECS[v].mem,
            VECS[v].we, VECS[v].wn, VECS[v].wd);
      @(negedge clk);
      check(int'(VECS[v].rq), VECS[v].ec, VECS[v].ed, VECS[v].el);
      idle(VECS[v].el);
      @(negedge clk);
      check(7, VECS[v].ec, VECS[v].ed, VECS[v].el); // R7 sticky, no store
    end

    // R8 and R6: violations during reset ignored; latest loads memory (A7)
    rst_n = 1'b0;
    drive(8'h22, 32'h00000000, 1'b0, 8'hA7, 1'b1, 2'd1, 8'h44);
    repeat (2) @(negedge clk);
    check(8, 1'b0, 1'b0, 8'hA7);

    // R6: after release, memory equal to the loaded value gives no data error
    rst_n = 1'b1;
    drive(8'h00, 32'h00000000, 1'b0, 8'hA7, 1'b0, 2'd0, 8'h00);
    @(negedge clk);
    check(6, 1'b0, 1'b0, 8'hA7);

    // R7: latency; flag still low just before the edge, high just after
    drive(8'h0A, 32'hA7A7A7A7, 1'b1, 8'hA7, 1'b0, 2'd0, 8'h00);
    #8;
    check(7, 1'b0, 1'b0, 8'hA7);
    @(negedge clk);
    check(7, 1'b1, 1'b0, 8'hA7);

    // R7: data flag joins; R8: reset clears both
    drive(8'h00, 32'h00000000, 1'b0, 8'h01, 1'b0, 2'd0, 8'h00);
    @(negedge clk);
    check(7, 1'b1, 1'b1, 8'hA7);
    rst_n = 1'b0;
    @(negedge clk);
    check(8, 1'b0, 1'b0, 8'h01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule